// File: doc/BRIEF.md
# Fractional Slot Rate Throttle

This block bounds how many time slots each of four streams may occupy in every 64-slot frame of a shared link. Each stream carries a fixed-point rate: an integer count X and a 25-bit fraction Y. Software derives X as the floor of the desired average slots per frame and Y as the leftover fraction times 2^25, rounded up. On every frame boundary each stream adds Y to its own 25-bit accumulator. A stream receives X slots for that frame, or X+1 when the addition carries out of the accumulator. Over many frames the average grant therefore converges on X + Y/2^25.

New rates are written into a staging register and raise a per-stream pending flag. They move into the active register at the next frame boundary, and that same boundary clears the flag. The accumulator keeps its value across rate changes, so the fractional phase is not lost. Each grant is clipped to the stream's slot allocation, which is sampled at the frame boundary. A sticky flag per stream records that clipping took place.

Top module: `slot_rate_throttle`

## Requirements
- R1: Four streams, selected by cfg_idx_i (0..3) when cfg_we_i is high, each hold an independent integer rate and fractional rate; a write to one stream never alters another stream's grant.
- R2: On a cycle with frame_i high, each stream sets acc = (acc + Y) mod 2^25 and computes raw = X + carry-out of that addition; grant_o (stream s in bits [7*s+6:7*s]) and a one-cycle grant_vld_o pulse appear in the next cycle.
- R3: Over N frames starting from accumulator value A, a stream with constant rate receives N*X + floor((A + N*Y) / 2^25) slots when no clipping occurs.
- R4: A write sets the stream's pending_o bit in the following cycle; the bit clears after the first frame boundary that has no write to the same stream.
- R5: New rates affect only grants computed at a frame boundary after the write; grant_o holds its value on every cycle without frame_i.
- R6: A rate update does not clear the fractional accumulator.
- R7: A stream with X=0 and Y=0 is granted zero slots.
- R8: The grant is min(raw, alloc), where alloc is the stream's alloc_i field (bits [7*s+6:7*s]) sampled at the frame boundary.
- R9: capped_o for a stream sets when raw exceeds alloc and stays set until reset.
- R10: A write that coincides with frame_i for the same stream lets that boundary use the earlier staged rate; the new rate stays pending until the next boundary.
- R11: After reset, grant_o, grant_vld_o, pending_o, capped_o and all accumulators are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Link clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Rate write strobe |
| cfg_idx_i | input | 2 | Stream selected by the write |
| cfg_int_i | input | 7 | Integer slots per frame (X) |
| cfg_frac_i | input | 25 | Fractional rate scaled by 2^25 (Y) |
| frame_i | input | 1 | Frame boundary pulse |
| alloc_i | input | 28 | Per-stream slot allocation, 7 bits each |
| grant_o | output | 28 | Per-stream granted slots, 7 bits each |
| grant_vld_o | output | 1 | Pulses one cycle after frame_i |
| pending_o | output | 4 | Per-stream rate update pending |
| capped_o | output | 4 | Per-stream sticky clipping flag |

## Verification
Every cycle, the assertions check several properties. A write always raises pending. A boundary with no competing write always clears it. The accumulator and the grant never move outside a boundary. A grant never exceeds the allocation sampled with it. The clipping flag never falls, and a zero rate always yields zero. The bench scenarios cover what needs history. These are the long-run average over hundreds of frames, the alternating X/X+1 sequence of a half fraction, and the carry that survives a rate change. They also cover the ordering when a write collides with a boundary, and the isolation between streams.

// File: rtl/srt_pkg.sv
package srt_pkg;
  parameter int unsigned NUM_STREAMS     = 4;
  parameter int unsigned SLOTS_PER_FRAME = 64;
  parameter int unsigned FRAC_W          = 25;
  localparam int unsigned CNT_W = $clog2(SLOTS_PER_FRAME + 1);
  localparam int unsigned IDX_W = $clog2(NUM_STREAMS);
  localparam int unsigned RAW_W = CNT_W + 1;

  typedef struct packed {
    logic [CNT_W-1:0]  x;
    logic [FRAC_W-1:0] y;
  } rate_t;
endpackage

// File: rtl/srt_rate_reg.sv
module srt_rate_reg
  import srt_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  we_i,
  input  rate_t rate_i,
  input  logic  frame_i,
  output rate_t eff_o,
  output logic  pending_o
);
  rate_t stg_q, act_q;
  logic  pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q  <= '0;
      act_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (frame_i && pend_q) act_q <= stg_q;
      if (we_i) stg_q <= rate_i;
      if (we_i)         pend_q <= 1'b1;
      else if (frame_i) pend_q <= 1'b0;
    end
  end

  // staged value is the one a boundary commits
  assign eff_o     = pend_q ? stg_q : act_q;
  assign pending_o = pend_q;

  AST_PEND_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> pending_o); // R4
  AST_PEND_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && !we_i) |=> !pending_o); // R4
  AST_COLLIDE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && we_i) |=> pending_o); // R10
endmodule

// File: rtl/srt_frac_accum.sv
module srt_frac_accum
  import srt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_i,
  input  rate_t            rate_i,
  output logic [RAW_W-1:0] raw_o
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;

  assign sum   = {1'b0, acc_q} + {1'b0, rate_i.y};
  assign raw_o = RAW_W'(rate_i.x) + RAW_W'(sum[FRAC_W]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (frame_i) acc_q <= sum[FRAC_W-1:0];
  end

  AST_ACC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(acc_q)); // R2
  AST_ACC_ZERO_FRAC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && rate_i.y == '0) |=> $stable(acc_q)); // R6
endmodule

// File: rtl/srt_grant_cap.sv
module srt_grant_cap
  import srt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_i,
  input  logic [RAW_W-1:0] raw_i,
  input  logic [CNT_W-1:0] alloc_i,
  output logic [CNT_W-1:0] grant_o,
  output logic             capped_o
);
  logic             over;
  logic [CNT_W-1:0] grant_q;
  logic             cap_q;

  assign over = raw_i > RAW_W'(alloc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q <= '0;
      cap_q   <= 1'b0;
    end else if (frame_i) begin
      grant_q <= over ? alloc_i : raw_i[CNT_W-1:0];
      if (over) cap_q <= 1'b1;
    end
  end

  assign grant_o  = grant_q;
  assign capped_o = cap_q;

  AST_GRANT_LE_ALLOC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |=> grant_o <= $past(alloc_i)); // R8
  AST_CAP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capped_o |=> capped_o); // R9
  AST_GRANT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(grant_o)); // R5
endmodule

// File: rtl/slot_rate_throttle.sv
module slot_rate_throttle
  import srt_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cfg_we_i,
  input  logic [IDX_W-1:0]             cfg_idx_i,
  input  logic [CNT_W-1:0]             cfg_int_i,
  input  logic [FRAC_W-1:0]            cfg_frac_i,
  input  logic                         frame_i,
  input  logic [NUM_STREAMS*CNT_W-1:0] alloc_i,
  output logic [NUM_STREAMS*CNT_W-1:0] grant_o,
  output logic                         grant_vld_o,
  output logic [NUM_STREAMS-1:0]       pending_o,
  output logic [NUM_STREAMS-1:0]       capped_o
);
  rate_t wr_rate;
  logic  vld_q;

  assign wr_rate.x = cfg_int_i;
  assign wr_rate.y = cfg_frac_i;

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_str
    rate_t            eff;
    logic [RAW_W-1:0] raw;
    logic             we;

    assign we = cfg_we_i && (cfg_idx_i == IDX_W'(s));

    srt_rate_reg u_reg (
      .clk_i, .rst_ni, .we_i(we), .rate_i(wr_rate), .frame_i,
      .eff_o(eff), .pending_o(pending_o[s])
    );

    srt_frac_accum u_acc (
      .clk_i, .rst_ni, .frame_i, .rate_i(eff), .raw_o(raw)
    );

    srt_grant_cap u_cap (
      .clk_i, .rst_ni, .frame_i, .raw_i(raw),
      .alloc_i(alloc_i[s*CNT_W +: CNT_W]),
      .grant_o(grant_o[s*CNT_W +: CNT_W]),
      .capped_o(capped_o[s])
    );

    AST_ZERO_RATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frame_i && eff.x == '0 && eff.y == '0) |=> grant_o[s*CNT_W +: CNT_W] == '0); // R7
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= 1'b0;
    else         vld_q <= frame_i;
  end
  assign grant_vld_o = vld_q;

  AST_VLD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |=> grant_vld_o); // R2
endmodule

// File: tb/slot_rate_throttle_test.sv
module slot_rate_throttle_test;
  localparam int NS = 4;
  localparam int CW = 7;
  localparam int FW = 25;
  localparam longint MOD = 64'd1 << FW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [1:0]    idx = '0;
  logic [CW-1:0] xin = '0;
  logic [FW-1:0] yin = '0;
  logic          frame = 1'b0;
  logic [NS*CW-1:0] alloc;
  logic [NS*CW-1:0] grant;
  logic          vld;
  logic [NS-1:0] pend, capd;

  int n_chk = 0, n_fail = 0;

  // reference state
  longint m_ax[NS], m_ay[NS], m_sx[NS], m_sy[NS], m_acc[NS];
  int     m_gr[NS], m_al[NS];
  bit     m_pd[NS], m_cp[NS];

  slot_rate_throttle uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_idx_i(idx),
    .cfg_int_i(xin), .cfg_frac_i(yin), .frame_i(frame), .alloc_i(alloc),
    .grant_o(grant), .grant_vld_o(vld), .pending_o(pend), .capped_o(capd)
  );

  always #5 clk = ~clk;

  always_comb
    for (int s = 0; s < NS; s++) alloc[s*CW +: CW] = CW'(m_al[s]);

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    for (int s = 0; s < NS; s++) begin
      chk({req, " grant"}, grant[s*CW +: CW], m_gr[s]);
      chk({req, " pending"}, pend[s], m_pd[s]);
      chk({req, " capped"}, capd[s], m_cp[s]);
    end
  endtask

  // one clock cycle, optional write and optional boundary
  task automatic cyc(bit f, bit w, int i, int x, longint y);
    @(negedge clk);
    frame = f; we = w; idx = 2'(i); xin = CW'(x); yin = FW'(y);
    @(negedge clk);
    frame = 1'b0; we = 1'b0;
    if (f) begin
      for (int s = 0; s < NS; s++) begin
        longint sum; int raw;
        if (m_pd[s]) begin m_ax[s] = m_sx[s]; m_ay[s] = m_sy[s]; m_pd[s] = 0; end
        sum = m_acc[s] + m_ay[s];
        raw = int'(m_ax[s]) + ((sum >= MOD) ? 1 : 0);
        m_acc[s] = sum % MOD;
        if (raw > m_al[s]) begin m_gr[s] = m_al[s]; m_cp[s] = 1; end
        else m_gr[s] = raw;
      end
    end
    if (w) begin m_sx[i] = x; m_sy[i] = y; m_pd[i] = 1; end
    chk("R2 vld", vld, f);
  endtask

  task automatic t_reset();
    for (int s = 0; s < NS; s++) begin
      m_ax[s] = 0; m_ay[s] = 0; m_sx[s] = 0; m_sy[s] = 0; m_acc[s] = 0;
      m_gr[s] = 0; m_al[s] = 64; m_pd[s] = 0; m_cp[s] = 0;
    end
    #2;
    chk("R11 grant", grant, 0);
    chk("R11 vld", vld, 0);
    chk("R11 pending", pend, 0);
    chk("R11 capped", capd, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cyc(1, 0, 0, 0, 0);
    chk_all("R11 R7 first frame");
  endtask

  task automatic t_integer();
    cyc(0, 1, 0, 3, 0);
    for (int k = 0; k < 3; k++) begin
      cyc(1, 0, 0, 0, 0);
      chk("R1 stream0", grant[0 +: CW], 3);
      chk_all("R1 R2 integer");
    end
  endtask

  task automatic t_pending();
    cyc(0, 1, 1, 4, 0);
    chk("R4 set", pend[1], 1);
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    chk("R5 unchanged", grant[CW +: CW], 0);
    chk_all("R5 before boundary");
    cyc(1, 0, 0, 0, 0);
    chk("R4 cleared", pend[1], 0);
    chk("R5 applied", grant[CW +: CW], 4);
  endtask

  task automatic t_fraction();
    int extra = 0;
    cyc(0, 1, 2, 2, MOD / 2);
    for (int k = 0; k < 6; k++) begin
      cyc(1, 0, 0, 0, 0);
      chk("R2 half", grant[2*CW +: CW], (k % 2 == 1) ? 3 : 2);
      extra += grant[2*CW +: CW] - 2;
    end
    chk("R3 half extras", extra, 3);
  endtask

  task automatic t_keep_acc();
    cyc(1, 0, 0, 0, 0);               // acc of stream 2 now at half
    cyc(0, 1, 2, 0, MOD / 2);
    cyc(1, 0, 0, 0, 0);
    chk("R6 carry kept", grant[2*CW +: CW], 1);
    chk_all("R6 all");
  endtask

  task automatic t_long();
    int total = 0;
    cyc(0, 1, 3, 1, 64'd11184811);
    for (int k = 0; k < 300; k++) begin
      cyc(1, 0, 0, 0, 0);
      total += grant[3*CW +: CW];
    end
    chk("R3 long-run", total, 400);
    chk_all("R3 final");
  endtask

  task automatic t_zero();
    cyc(0, 1, 1, 0, 0);
    cyc(1, 0, 0, 0, 0);
    chk("R7 zero", grant[CW +: CW], 0);
  endtask

  task automatic t_cap();
    m_al[0] = 2;
    cyc(1, 0, 0, 0, 0);
    chk("R8 clipped", grant[0 +: CW], 2);
    chk("R9 set", capd[0], 1);
    chk("R1 others clear", capd[3:1], 0);
    m_al[0] = 64;
    cyc(1, 0, 0, 0, 0);
    chk("R8 unclipped", grant[0 +: CW], 3);
    chk("R9 sticky", capd[0], 1);
  endtask

  task automatic t_collide();
    cyc(0, 1, 1, 5, 0);
    cyc(1, 1, 1, 6, 0);
    chk("R10 old staged", grant[CW +: CW], 5);
    chk("R10 still pending", pend[1], 1);
    cyc(1, 0, 0, 0, 0);
    chk("R10 new applied", grant[CW +: CW], 6);
    chk("R10 cleared", pend[1], 0);
    chk_all("R10 all");
  endtask

  initial begin
    t_reset();
    t_integer();
    t_pending();
    t_fraction();
    t_keep_acc();
    t_long();
    t_zero();
    t_cap();
    t_collide();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule